// File: doc/BRIEF.md
# Boot Image Stream Parser

This block reads a boot image from a transport and writes it into on-chip memory. The transport delivers units over a valid/ready handshake. A unit is either a 16-bit word or a byte carried in bits [7:0]. The first unit or units form a key, and the key decides the unit width for the rest of the stream. After the key, the parser drops a fixed run of reserved words and captures a 32-bit entry point. It then processes a chain of self-addressed blocks. Each block gives a word count, a 32-bit destination and then that many data words, and the data words are written to consecutive addresses. A block whose count is zero ends the image.

The input side follows valid/ready rules. A unit is taken in a cycle where both `in_valid` and `in_ready` are high. The source may hold `in_valid` low for any number of cycles. `in_ready` can fall whenever the parser cannot take a unit.

The memory side is a valid/ready write port. A write is presented on `mem_wr` with `mem_addr` and `mem_data`, and it completes in a cycle where `mem_ready` is high. While `mem_ready` stays low, the write and its address and data are held unchanged.

When the image ends, `done` pulses for one cycle and `entry_point` holds the captured address until reset. A malformed key raises `fmt_err` instead. The code that consumes `entry_point` and jumps to it lies outside this block.

Top module: `boot_stream_parser`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_wr`, `done` and `fmt_err` are low and `in_ready` is high, because the parser waits for a key unit.
- R2: A first unit equal to 0x10AA selects word mode. Every later unit is then a full 16-bit word taken from `in_data[15:0]`.
- R3: A first unit whose value is not 0x10AA but whose bits [7:0] equal 0xAA, followed by a unit whose bits [7:0] equal 0x08, selects byte mode. Each later word is then built from two units: the low byte from the first and the high byte from the second, each taken from `in_data[7:0]`. Bits [15:8] of those units are ignored.
- R4: A first unit that fits neither key, or an 0xAA first byte followed by a second byte other than 0x08, sets `fmt_err`. `fmt_err` stays high until reset, and no memory write is ever issued.
- R5: The 8 words that follow the key are consumed and have no effect on the writes or on `entry_point`.
- R6: The next two words form `entry_point`, most significant half first, then bits [15:0].
- R7: Each block is a count word N, then destination bits [31:16], then destination bits [15:0], then N data words. Data word k of the block is written to the destination plus k, and the address wraps modulo 2^32.
- R8: A count word of zero ends the image. `done` then pulses high for exactly one cycle, and only after the last write has been accepted.
- R9: While `mem_wr` is high and `mem_ready` is low, the next cycle keeps `mem_wr` high with `mem_addr` and `mem_data` unchanged. Each data word produces exactly one accepted write, and no write is lost or repeated.
- R10: Gaps in `in_valid` and stalls on `mem_ready` do not change the sequence of accepted writes or `entry_point`.
- R11: After `done` or `fmt_err`, `in_ready` stays low and `entry_point` stays unchanged until reset, and any further units have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A stream unit is offered |
| in_ready | output | 1 | The parser takes the offered unit this cycle |
| in_data | input | 16 | Stream unit; in byte mode only [7:0] is used |
| mem_wr | output | 1 | Write request to memory |
| mem_ready | input | 1 | Memory accepts the presented write this cycle |
| mem_addr | output | 32 | Write address |
| mem_data | output | 16 | Write data |
| done | output | 1 | One-cycle pulse at the end of the image |
| fmt_err | output | 1 | Key rejected; sticky until reset |
| entry_point | output | 32 | Captured entry address |

## Verification
Two events can fall in the same cycle:
- A write held by a low `mem_ready` finally completes.
- The next block's count word, or the zero terminator, arrives at the input.

The bench provokes this by stalling `mem_ready` at random while it feeds back-to-back blocks with random input gaps. It judges the outcome in two ways. First, the recorded list of accepted writes must match the list predicted from the stream exactly: no write may be dropped or repeated. Second, `done` must not rise until the final held write has been accepted.

// File: rtl/boot_parse_pkg.sv
package boot_parse_pkg;

  localparam int UNIT_W = 16;
  localparam logic [UNIT_W-1:0] KEY_WIDE = 16'h10AA;
  localparam logic [7:0] KEY_NARROW_LO = 8'hAA;
  localparam logic [7:0] KEY_NARROW_HI = 8'h08;

  typedef enum logic [3:0] {
    ST_KEY_A,
    ST_KEY_B,
    ST_SKIP,
    ST_EP_HI,
    ST_EP_LO,
    ST_COUNT,
    ST_DST_HI,
    ST_DST_LO,
    ST_DATA,
    ST_FLUSH,
    ST_FINISHED,
    ST_FAULT
  } parse_state_t;

endpackage

// File: rtl/bsp_unit_packer.sv
module bsp_unit_packer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pack_en,
  input  logic          halt,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          w_valid,
  input  logic          w_ready,
  output logic [DW-1:0] w_data
);
  localparam int HW = DW / 2;

  logic          second_half;
  logic [HW-1:0] low_part;

  always_comb begin
    w_valid  = 1'b0;
    w_data   = in_data;
    in_ready = 1'b0;
    if (!halt) begin
      if (!pack_en) begin
        w_valid  = in_valid;
        in_ready = w_ready;
      end else if (!second_half) begin
        in_ready = 1'b1;
      end else begin
        w_valid  = in_valid;
        w_data   = {in_data[HW-1:0], low_part};
        in_ready = w_ready;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      second_half <= 1'b0;
      low_part    <= '0;
    end else if (pack_en && in_valid && in_ready) begin
      second_half <= ~second_half;
      if (!second_half) low_part <= in_data[HW-1:0];
    end
  end

endmodule

// File: rtl/bsp_write_port.sv
module bsp_write_port #(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          mem_wr,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);

  assign req_ready = !mem_wr || mem_ready;
  assign busy      = mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else if (req_ready) begin
      mem_wr <= req_valid;
      if (req_valid) begin
        mem_addr <= req_addr;
        mem_data <= req_data;
      end
    end
  end

endmodule

// File: rtl/bsp_sequencer.sv
module bsp_sequencer
  import boot_parse_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SKIP_WORDS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            w_valid,
  output logic            w_ready,
  input  logic [DW-1:0]   w_data,
  output logic            pack_en,
  output logic            halt,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [2*DW-1:0] wr_addr,
  output logic [DW-1:0]   wr_data,
  input  logic            wr_busy,
  output logic            done,
  output logic            fmt_err,
  output logic [2*DW-1:0] entry_point
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] SKIP_LAST = DW'(1);
  localparam logic [DW-1:0] SKIP_INIT = DW'(SKIP_WORDS);

  parse_state_t  state;
  logic          byte_mode;
  logic [DW-1:0] remain;
  logic [AW-1:0] cur_addr;
  logic          take;

  assign pack_en  = byte_mode;
  assign halt     = (state == ST_FLUSH) || (state == ST_FINISHED) || (state == ST_FAULT);
  assign wr_valid = (state == ST_DATA) && w_valid;
  assign wr_addr  = cur_addr;
  assign wr_data  = w_data;
  assign take     = w_valid && w_ready;

  always_comb begin
    case (state)
      ST_KEY_A, ST_KEY_B, ST_SKIP, ST_EP_HI, ST_EP_LO,
      ST_COUNT, ST_DST_HI, ST_DST_LO: w_ready = 1'b1;
      ST_DATA:                        w_ready = wr_ready;
      default:                        w_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_KEY_A;
      byte_mode   <= 1'b0;
      remain      <= '0;
      cur_addr    <= '0;
      entry_point <= '0;
      done        <= 1'b0;
      fmt_err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_KEY_A: if (take) begin
          if (w_data == KEY_WIDE) begin
            byte_mode <= 1'b0;
            remain    <= SKIP_INIT;
            state     <= ST_SKIP;
          end else if (w_data[7:0] == KEY_NARROW_LO) begin
            state <= ST_KEY_B;
          end else begin
            fmt_err <= 1'b1;
            state   <= ST_FAULT;
          end
        end
        ST_KEY_B: if (take) begin
          if (w_data[7:0] == KEY_NARROW_HI) begin
            byte_mode <= 1'b1;
            remain    <= SKIP_INIT;
            state     <= ST_SKIP;
          end else begin
            fmt_err <= 1'b1;
            state   <= ST_FAULT;
          end
        end
        ST_SKIP: if (take) begin
          remain <= remain - 1'b1;
          if (remain == SKIP_LAST) state <= ST_EP_HI;
        end
        ST_EP_HI: if (take) begin
          entry_point[AW-1:DW] <= w_data;
          state                <= ST_EP_LO;
        end
        ST_EP_LO: if (take) begin
          entry_point[DW-1:0] <= w_data;
          state               <= ST_COUNT;
        end
        ST_COUNT: if (take) begin
          if (w_data == '0) begin
            state <= ST_FLUSH;
          end else begin
            remain <= w_data;
            state  <= ST_DST_HI;
          end
        end
        ST_DST_HI: if (take) begin
          cur_addr[AW-1:DW] <= w_data;
          state             <= ST_DST_LO;
        end
        ST_DST_LO: if (take) begin
          cur_addr[DW-1:0] <= w_data;
          state            <= ST_DATA;
        end
        ST_DATA: if (take) begin
          cur_addr <= cur_addr + 1'b1;
          remain   <= remain - 1'b1;
          if (remain == SKIP_LAST) state <= ST_COUNT;
        end
        ST_FLUSH: if (!wr_busy) begin
          done  <= 1'b1;
          state <= ST_FINISHED;
        end
        ST_FINISHED: state <= ST_FINISHED;
        default:     state <= ST_FAULT;
      endcase
    end
  end

endmodule

// File: rtl/boot_stream_parser.sv
module boot_stream_parser #(
  parameter int DW         = 16,
  parameter int SKIP_WORDS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  output logic            mem_wr,
  input  logic            mem_ready,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_data,
  output logic            done,
  output logic            fmt_err,
  output logic [2*DW-1:0] entry_point
);
  localparam int AW = 2 * DW;

  logic          w_valid, w_ready, pack_en, halt;
  logic [DW-1:0] w_data;
  logic          wr_valid, wr_ready, wr_busy;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  bsp_unit_packer #(.DW(DW)) u_packer (
    .clk(clk), .rst(rst), .pack_en(pack_en), .halt(halt),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data)
  );

  bsp_sequencer #(.DW(DW), .SKIP_WORDS(SKIP_WORDS)) u_seq (
    .clk(clk), .rst(rst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .pack_en(pack_en), .halt(halt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_busy(wr_busy), .done(done), .fmt_err(fmt_err), .entry_point(entry_point)
  );

  bsp_write_port #(.DW(DW), .AW(AW)) u_wport (
    .clk(clk), .rst(rst),
    .req_valid(wr_valid), .req_ready(wr_ready), .req_addr(wr_addr), .req_data(wr_data),
    .busy(wr_busy), .mem_wr(mem_wr), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            mem_wr,
  input logic            mem_ready,
  input logic [2*DW-1:0] mem_addr,
  input logic [DW-1:0]   mem_data,
  input logic            done,
  input logic            fmt_err,
  input logic [2*DW-1:0] entry_point
);
  logic finished;

  always_ff @(posedge clk) begin
    if (rst) finished <= 1'b0;
    else if (done) finished <= 1'b1;
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_AFTER_WRITES: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_wr); // R8

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> (!mem_wr && !in_ready)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> fmt_err); // R4

  AST_END_FROZEN: assert property (@(posedge clk) disable iff (rst)
    finished |-> (!in_ready && $stable(entry_point))); // R11

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(done && fmt_err)); // R11

endmodule

bind boot_stream_parser bsp_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .mem_wr(mem_wr), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .done(done), .fmt_err(fmt_err),
  .entry_point(entry_point)
);

// File: tb/boot_stream_parser_tb.sv
module boot_stream_parser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        mem_wr;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;
  logic        done;
  logic        fmt_err;
  logic [31:0] entry_point;

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  bit stall_en = 1'b0;
  bit gap_en = 1'b0;
  bit cur_byte = 1'b0;

  logic [15:0] units[$];
  logic [47:0] exp_wr[$];
  logic [47:0] got_wr[$];

  boot_stream_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .done(done), .fmt_err(fmt_err), .entry_point(entry_point)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) mem_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_wr && mem_ready) got_wr.push_back({mem_addr, mem_data});
      if (done) done_cnt++;
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=%0d cycles expected=<%0d", MAX_CYCLES, MAX_CYCLES);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    got_wr.delete();
    done_cnt = 0;
  endtask

  task automatic send(input logic [15:0] u);
    bit r;
    if (gap_en && $urandom_range(0, 2) == 0) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_data = u;
    forever begin
      #1 r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic add_word(input logic [15:0] w);
    if (cur_byte) begin
      units.push_back({8'hC3, w[7:0]});
      units.push_back({8'h5C, w[15:8]});
    end else begin
      units.push_back(w);
    end
  endtask

  task automatic begin_stream(input bit byte_mode, input logic [31:0] ep);
    units.delete();
    exp_wr.delete();
    cur_byte = 1'b0;
    if (byte_mode) begin
      units.push_back(16'h00AA);
      units.push_back(16'h0008);
    end else begin
      units.push_back(16'h10AA);
    end
    cur_byte = byte_mode;
    for (int i = 0; i < 8; i++) add_word(16'h0101 + 16'(i));  // R5: nonzero junk
    add_word(ep[31:16]);
    add_word(ep[15:0]);
  endtask

  task automatic add_block(input logic [31:0] addr, input int n, input logic [15:0] seed);
    add_word(16'(n));
    add_word(addr[31:16]);
    add_word(addr[15:0]);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = seed + 16'(i * 16'h0111);
      add_word(d);
      exp_wr.push_back({addr + 32'(i), d});
    end
  endtask

  task automatic play_and_check(input string req, input logic [31:0] ep);
    add_word(16'h0000);
    foreach (units[i]) send(units[i]);
    for (int c = 0; c < 2000 && done_cnt == 0; c++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, {req, " R8 done pulse count"}, 64'(done_cnt), 64'd1);
    chk(fmt_err == 1'b0, {req, " no error"}, 64'(fmt_err), 64'd0);
    chk(got_wr.size() == exp_wr.size(), {req, " R7 write count"}, 64'(got_wr.size()), 64'(exp_wr.size()));
    if (got_wr.size() == exp_wr.size())
      foreach (exp_wr[i])
        chk(got_wr[i] == exp_wr[i], {req, " R7 write addr/data"}, 64'(got_wr[i]), 64'(exp_wr[i]));
    chk(entry_point == ep, {req, " R6 entry point"}, 64'(entry_point), 64'(ep));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!mem_wr && !done && !fmt_err, "R1 outputs in reset", {mem_wr, done, fmt_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready for key", 64'(in_ready), 1);
    chk(!mem_wr && !done && !fmt_err, "R1 idle after reset", {mem_wr, done, fmt_err}, 0);
  endtask

  task automatic t_word();
    do_reset();
    begin_stream(1'b0, 32'h003F_8000);
    add_block(32'h003F_9010, 5, 16'h1000);
    add_block(32'h0000_7620, 2, 16'hA5A5);
    play_and_check("R2 R5 word mode", 32'h003F_8000);
  endtask

  task automatic t_byte();
    do_reset();
    begin_stream(1'b1, 32'h1234_5678);
    add_block(32'h0008_0000, 4, 16'hBEEF);
    add_block(32'h0008_0100, 1, 16'h00FF);
    play_and_check("R3 byte mode", 32'h1234_5678);
  endtask

  task automatic t_stall();
    do_reset();
    stall_en = 1'b1;
    gap_en = 1'b1;
    begin_stream(1'b0, 32'hCAFE_0001);
    add_block(32'h0001_0000, 7, 16'h2222);
    add_block(32'h0002_0000, 1, 16'h3333);
    add_block(32'h0003_0000, 3, 16'h4444);
    play_and_check("R9 R10 word stalls", 32'hCAFE_0001);
    do_reset();
    stall_en = 1'b1;
    begin_stream(1'b1, 32'h0BAD_F00D);
    add_block(32'h0000_4000, 6, 16'h7777);
    add_block(32'h0000_5000, 2, 16'h8888);
    play_and_check("R9 R10 byte stalls", 32'h0BAD_F00D);
    stall_en = 1'b0;
    gap_en = 1'b0;
  endtask

  task automatic t_wrap();
    do_reset();
    begin_stream(1'b0, 32'h0000_0040);
    add_block(32'hFFFF_FFFE, 4, 16'h9000);
    play_and_check("R7 address wrap", 32'h0000_0040);
  endtask

  task automatic t_after_done();
    logic [31:0] ep_before;
    bit saw_ready;
    t_word();
    ep_before = entry_point;
    saw_ready = 1'b0;
    in_valid = 1'b1;
    in_data = 16'h0003;
    for (int i = 0; i < 6; i++) begin
      #1 if (in_ready) saw_ready = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(!saw_ready, "R11 no input taken after done", 64'(saw_ready), 0);
    chk(entry_point == ep_before, "R11 entry point frozen", 64'(entry_point), 64'(ep_before));
    chk(done_cnt == 1, "R11 no second done", 64'(done_cnt), 1);
  endtask

  task automatic t_badkey(input logic [15:0] first, input bit two, input logic [15:0] second, input string tag);
    bit saw_ready;
    do_reset();
    send(first);
    if (two) send(second);
    repeat (2) @(negedge clk);
    chk(fmt_err == 1'b1, {tag, " R4 error raised"}, 64'(fmt_err), 1);
    saw_ready = 1'b0;
    in_valid = 1'b1;
    in_data = 16'h10AA;
    for (int i = 0; i < 5; i++) begin
      #1 if (in_ready) saw_ready = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(!saw_ready, {tag, " R11 input blocked after error"}, 64'(saw_ready), 0);
    chk(fmt_err == 1'b1 && done_cnt == 0, {tag, " R4 error sticky, no done"}, {fmt_err, 8'(done_cnt)}, 64'h100);
    chk(got_wr.size() == 0, {tag, " R4 no writes"}, 64'(got_wr.size()), 0);
  endtask

  initial begin
    t_reset();
    t_word();
    t_byte();
    t_stall();
    t_wrap();
    t_after_done();
    t_badkey(16'h1234, 1'b0, 16'h0000, "bad first unit");
    t_badkey(16'h00AA, 1'b1, 16'h0009, "bad second byte");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule